// File: doc/BRIEF.md
# Grouped-Priority Interrupt Controller

This block collects 24 interrupt sources, arranged as three priority groups of eight (A, B and C), and presents one interrupt line to the processor. Every source has a pending bit and a mask bit. A pending bit whose mask bit is set makes the source eligible for arbitration. The eight sources of group C are external inputs, and each of them can be set to edge or level sense. Sources 0 to 7 are group A, 8 to 15 are group B, and 16 to 23 are group C.

Each group has a priority word made of eight 3-bit slots, one per ranking position. Software writes the member code (0 to 7) of a source into a slot to place that source at that position. In grouped mode the whole of group A ranks above group B, and group B ranks above group C. A spread mode interleaves the positions of groups A and B. An override field names one source that beats every other source whenever it is eligible. The number of the winning source is read from a vector register. Source n reports as n+1, and 0 means that no source is eligible.

Software reaches all registers through a single-cycle 32-bit port with a word address. Writes take effect at the clock edge. Reads are combinational from the address. Per-source bits use descending numbering: source n sits at bit 31-n.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset, the configuration, mask, pending, sense and vector reads are all 0, `irq_o` is low, and each priority word holds the identity placement (slot p holds code p).
- R2: Word addresses are 0 config, 1 pending, 2 mask, 3/4/5 priority of groups A/B/C, 6 sense, 7 vector. In the pending and mask registers, source n is bit 31-n, and bits 7:0 read 0.
- R3: A source that is pending but masked (its mask bit is 0) is not eligible. It does not raise `irq_o` and it does not appear in the vector.
- R4: In grouped mode the rank order is A slots 0..7, then B slots 0..7, then C slots 0..7. The 3-bit slot p starts at bit 20+(3-p)*3 for p<4 and at bit 4+(7-p)*3 for p>=4. Slot 0 is the highest rank.
- R5: Config bit 16 selects spread mode. The order is then A0, B0, A1, B1, … A7, B7, followed by the C slots.
- R6: Sense bit 15-i set makes external input i (source 16+i) edge-sensitive. A rising edge latches its pending bit, and the bit holds until a 1 is written to it in the pending register.
- R7: A level source's pending bit follows its input one cycle later. Writing a 1 to that bit has no effect.
- R8: Config bits 30:24 hold an override source number (n+1). When that source is eligible it wins over all others. The value 0 and values above 24 are ignored.
- R9: The vector register returns the winning source number in bits 6:0, or 0 if none is eligible. `irq_o` is high exactly when the vector is non-zero. Writes to the vector address are ignored.
- R10: An eligible source that no slot of its group names ranks after all placed sources. Among such sources, the lowest source index ranks first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 24 | Interrupt request inputs, source n on bit n |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench targets the cases that silently give the wrong winner. If a design decoded the slot offsets for the upper four positions incorrectly, a reordered group would report the wrong member. If the ordering ignored the group, a low group-A slot would lose to group B. A broken spread interleave would let A1 beat B0. The bench also drops a source out of every slot: a design without the fallback would hold `irq_o` high with a zero vector. On the sense side it checks a one-cycle pulse on an edge input, which must stay latched until it is cleared, and a write-1 to a level source, which must not clear it. It also checks override values that must be ignored: 0, out of range, and a masked source.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int GRP_N   = 3;
  localparam int GRP_SZ  = 8;
  localparam int SRC_N   = GRP_N * GRP_SZ;
  localparam int CODE_W  = $clog2(GRP_SZ);
  localparam int VEC_W   = 7;
  localparam int IDX_W   = $clog2(SRC_N);
  localparam int EXT_N   = GRP_SZ;
  localparam int EXT_BASE = SRC_N - EXT_N;

  typedef enum logic [2:0] {
    RA_CFG = 3'd0, RA_PEND = 3'd1, RA_MASK = 3'd2, RA_PRI_A = 3'd3,
    RA_PRI_B = 3'd4, RA_PRI_C = 3'd5, RA_SENSE = 3'd6, RA_VEC = 3'd7
  } reg_addr_e;

  function automatic int slot_lsb(input int p);
    return (p < 4) ? 20 + (3 - p) * 3 : 4 + (7 - p) * 3;
  endfunction

  function automatic logic [31:0] slot_mask();
    logic [31:0] m = '0;
    for (int p = 0; p < GRP_SZ; p++) m |= 32'(7) << slot_lsb(p);
    return m;
  endfunction

  function automatic logic [31:0] slot_ident();
    logic [31:0] m = '0;
    for (int p = 0; p < GRP_SZ; p++) m |= 32'(p) << slot_lsb(p);
    return m;
  endfunction

  function automatic logic [SRC_N-1:0] from_be(input logic [31:0] w);
    logic [SRC_N-1:0] r;
    for (int n = 0; n < SRC_N; n++) r[n] = w[31-n];
    return r;
  endfunction

  function automatic logic [31:0] to_be(input logic [SRC_N-1:0] v);
    logic [31:0] r = '0;
    for (int n = 0; n < SRC_N; n++) r[31-n] = v[n];
    return r;
  endfunction
endpackage

// File: rtl/irqc_pend.sv
module irqc_pend
  import irqc_pkg::*;
#(
  parameter int N = SRC_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] edge_mode_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] src_q, edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      edge_q <= '0;
    end else begin
      src_q  <= src_i;
      // a new edge wins over a simultaneous clear
      edge_q <= (edge_q & ~clr_i) | (src_i & ~src_q);
    end
  end

  for (genvar n = 0; n < N; n++) begin : g_src
    assign pend_o[n] = edge_mode_i[n] ? edge_q[n] : src_q[n];

    assert_edge_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode_i[n] && pend_o[n] && !clr_i[n]) |=> (pend_o[n] || !edge_mode_i[n]));
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
(
  input  logic [SRC_N-1:0]            elig_i,
  input  logic [GRP_N-1:0][31:0]      prio_i,
  input  logic                        spread_i,
  input  logic [VEC_W-1:0]            ovr_i,
  output logic [VEC_W-1:0]            vec_o
);
  logic [IDX_W-1:0] rank_id [SRC_N];
  logic [SRC_N-1:0] placed;
  logic             found;

  always_comb begin
    placed = '0;
    for (int s = 0; s < SRC_N; s++) rank_id[s] = '0;
    for (int g = 0; g < GRP_N; g++) begin
      for (int p = 0; p < GRP_SZ; p++) begin
        logic [CODE_W-1:0] code;
        int slot;
        code = prio_i[g][slot_lsb(p) +: CODE_W];
        slot = (spread_i && g < 2) ? p * 2 + g : g * GRP_SZ + p;
        rank_id[slot] = IDX_W'(g * GRP_SZ) + IDX_W'(code);
        placed[g * GRP_SZ + int'(code)] = 1'b1;
      end
    end

    vec_o = '0;
    found = 1'b0;
    for (int s = 0; s < SRC_N; s++) begin
      if (!found && elig_i[rank_id[s]]) begin
        vec_o = VEC_W'(rank_id[s]) + VEC_W'(1);
        found = 1'b1;
      end
    end
    for (int n = 0; n < SRC_N; n++) begin
      if (!found && elig_i[n] && !placed[n]) begin
        vec_o = VEC_W'(n + 1);
        found = 1'b1;
      end
    end
    if (ovr_i != '0 && ovr_i <= VEC_W'(SRC_N)) begin
      if (elig_i[IDX_W'(ovr_i - VEC_W'(1))]) vec_o = ovr_i;
    end
  end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import irqc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_N-1:0]  src_i,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam logic [31:0] PRIO_WMASK = slot_mask();
  localparam logic [31:0] PRIO_RST   = slot_ident();

  logic [VEC_W-1:0]        ovr_q;
  logic                    spread_q;
  logic [SRC_N-1:0]        mask_q;
  logic [GRP_N-1:0][31:0]  prio_q;
  logic [EXT_N-1:0]        sense_q;

  logic [SRC_N-1:0] clr, edge_mode, pend, elig;
  logic [VEC_W-1:0] vec;
  reg_addr_e        ra;

  assign ra  = reg_addr_e'(addr_i);
  assign clr = (wr_en_i && ra == RA_PEND) ? from_be(wdata_i) : '0;

  for (genvar n = 0; n < SRC_N; n++) begin : g_mode
    if (n >= EXT_BASE) begin : g_ext
      assign edge_mode[n] = sense_q[n - EXT_BASE];
    end else begin : g_int
      assign edge_mode[n] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q    <= '0;
      spread_q <= 1'b0;
      mask_q   <= '0;
      prio_q   <= {GRP_N{PRIO_RST}};
      sense_q  <= '0;
    end else if (wr_en_i) begin
      unique case (ra)
        RA_CFG: begin
          ovr_q    <= wdata_i[30:24];
          spread_q <= wdata_i[16];
        end
        RA_MASK:  mask_q    <= from_be(wdata_i);
        RA_PRI_A: prio_q[0] <= wdata_i & PRIO_WMASK;
        RA_PRI_B: prio_q[1] <= wdata_i & PRIO_WMASK;
        RA_PRI_C: prio_q[2] <= wdata_i & PRIO_WMASK;
        RA_SENSE: for (int i = 0; i < EXT_N; i++) sense_q[i] <= wdata_i[15-i];
        default: ;
      endcase
    end
  end

  irqc_pend #(.N(SRC_N)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (src_i),
    .clr_i       (clr),
    .edge_mode_i (edge_mode),
    .pend_o      (pend)
  );

  assign elig  = pend & mask_q;
  assign irq_o = |elig;

  irqc_arb u_arb (
    .elig_i   (elig),
    .prio_i   (prio_q),
    .spread_i (spread_q),
    .ovr_i    (ovr_q),
    .vec_o    (vec)
  );

  always_comb begin
    rdata_o = '0;
    unique case (ra)
      RA_CFG:   begin rdata_o[30:24] = ovr_q; rdata_o[16] = spread_q; end
      RA_PEND:  rdata_o = to_be(pend);
      RA_MASK:  rdata_o = to_be(mask_q);
      RA_PRI_A: rdata_o = prio_q[0];
      RA_PRI_B: rdata_o = prio_q[1];
      RA_PRI_C: rdata_o = prio_q[2];
      RA_SENSE: for (int i = 0; i < EXT_N; i++) rdata_o[15-i] = sense_q[i];
      RA_VEC:   rdata_o[VEC_W-1:0] = vec;
      default: ;
    endcase
  end

  logic [IDX_W-1:0] vec_idx, ovr_idx;
  logic             ovr_ok;
  assign vec_idx = (vec != '0 && vec <= VEC_W'(SRC_N)) ? IDX_W'(vec - VEC_W'(1)) : '0;
  assign ovr_ok  = ovr_q != '0 && ovr_q <= VEC_W'(SRC_N);
  assign ovr_idx = ovr_ok ? IDX_W'(ovr_q - VEC_W'(1)) : '0;

  assert_irq_vec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (vec != '0));
  assert_mask_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec != '0) |-> (mask_q[vec_idx] && pend[vec_idx]));
  assert_override_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_ok && pend[ovr_idx] && mask_q[ovr_idx]) |-> (vec == ovr_q));
  assert_vec_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec <= VEC_W'(SRC_N));
endmodule

// File: tb/sim_grp_irq_ctrl.sv
module sim_grp_irq_ctrl;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] src = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd7;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  grp_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // ---------------- reference model ----------------
  bit [23:0] m_srcq, m_edge, m_mask;
  bit [7:0]  m_sense;
  bit [6:0]  m_ovr;
  bit        m_spread;
  bit [31:0] m_prio [3];

  function automatic int lsb_of(int p);
    if (p < 4) return 20 + 3 * (3 - p);
    return 4 + 3 * (7 - p);
  endfunction

  function automatic bit [31:0] ident();
    bit [31:0] r = 0;
    for (int p = 0; p < 8; p++) r |= 32'(p) << lsb_of(p);
    return r;
  endfunction

  function automatic bit [31:0] fmask();
    bit [31:0] r = 0;
    for (int p = 0; p < 8; p++) r |= 32'(7) << lsb_of(p);
    return r;
  endfunction

  function automatic bit [23:0] unbe(bit [31:0] w);
    bit [23:0] r;
    for (int n = 0; n < 24; n++) r[n] = w[31-n];
    return r;
  endfunction

  function automatic bit m_pend(int n);
    if (n >= 16 && m_sense[n-16]) return m_edge[n];
    return m_srcq[n];
  endfunction

  function automatic int m_vec();
    int order[$];
    bit used [24];
    bit ok [24];
    for (int n = 0; n < 24; n++) begin
      ok[n] = m_pend(n) && m_mask[n];
      used[n] = 0;
    end
    if (m_ovr >= 1 && m_ovr <= 24 && ok[m_ovr-1]) return int'(m_ovr);
    for (int p = 0; p < 8; p++) begin
      order.push_back(int'((m_prio[0] >> lsb_of(p)) & 7));
      if (m_spread) order.push_back(8 + int'((m_prio[1] >> lsb_of(p)) & 7));
    end
    if (!m_spread)
      for (int p = 0; p < 8; p++) order.push_back(8 + int'((m_prio[1] >> lsb_of(p)) & 7));
    for (int p = 0; p < 8; p++) order.push_back(16 + int'((m_prio[2] >> lsb_of(p)) & 7));
    foreach (order[k]) used[order[k]] = 1;
    foreach (order[k]) if (ok[order[k]]) return order[k] + 1;
    for (int n = 0; n < 24; n++) if (ok[n] && !used[n]) return n + 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_srcq = 0; m_edge = 0; m_mask = 0; m_sense = 0; m_ovr = 0; m_spread = 0;
      for (int g = 0; g < 3; g++) m_prio[g] = ident();
    end else begin
      bit [23:0] c;
      c = (we && addr == 3'd1) ? unbe(wdata) : 24'd0;
      m_edge = (m_edge & ~c) | (src & ~m_srcq);
      m_srcq = src;
      if (we) begin
        case (addr)
          3'd0: begin m_ovr = wdata[30:24]; m_spread = wdata[16]; end
          3'd2: m_mask = unbe(wdata);
          3'd3: m_prio[0] = wdata & fmask();
          3'd4: m_prio[1] = wdata & fmask();
          3'd5: m_prio[2] = wdata & fmask();
          3'd6: for (int i = 0; i < 8; i++) m_sense[i] = wdata[15-i];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R3/R9)
  always @(negedge clk) begin
    #(PER/4);
    if (rst_n && !done) begin
      int mv;
      mv = m_vec();
      chk(irq == (mv != 0), "R9 irq vs model", irq, mv != 0);
      if (!we && addr == 3'd7) chk(rdata == 32'(mv), "R9 vector vs model", rdata, mv);
    end
  end

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(bit [2:0] a, bit [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = 3'd7;
  endtask

  task automatic rd(bit [2:0] a, output bit [31:0] d);
    @(negedge clk); we = 0; addr = a;
    #(PER/8); d = rdata;
  endtask

  task automatic rd_chk(bit [2:0] a, bit [31:0] exp, string tag);
    bit [31:0] d;
    rd(a, d);
    chk(d == exp, tag, d, exp);
    @(negedge clk); addr = 3'd7;
  endtask

  task automatic set_src(int n, bit v);
    @(negedge clk); src[n] = v;
  endtask

  initial begin
    #(PER * 50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [31:0] pa, pb;
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    rd_chk(3'd7, 0, "R1 vector after reset");
    rd_chk(3'd1, 0, "R1 pending after reset");
    rd_chk(3'd2, 0, "R1 mask after reset");
    rd_chk(3'd0, 0, "R1 config after reset");
    rd_chk(3'd6, 0, "R1 sense after reset");
    rd_chk(3'd4, ident(), "R1 group B identity placement");
    chk(irq == 0, "R1 irq after reset", irq, 0);

    // R3 masked source stays out
    set_src(3, 1); step(2);
    rd_chk(3'd7, 0, "R3 masked source in vector");
    chk(irq == 0, "R3 masked source raises irq", irq, 0);
    wr(3'd2, 32'hFFFF_FF00);
    rd_chk(3'd7, 4, "R3 unmasked source 3");
    rd_chk(3'd1, 32'h1000_0000, "R2 pending bit of source 3");
    rd_chk(3'd2, 32'hFFFF_FF00, "R2 mask readback");

    // R4 grouped ranking and slot offsets
    set_src(10, 1); step(2);
    rd_chk(3'd7, 4, "R4 group A above group B");
    pa = ident() & ~(32'd7 << lsb_of(3)) & ~(32'd7 << lsb_of(7));
    pa |= (32'd7 << lsb_of(3)) | (32'd3 << lsb_of(7));
    wr(3'd3, pa);
    rd_chk(3'd7, 4, "R4 slot 7 of A still above B");
    set_src(3, 0); step(2);
    rd_chk(3'd7, 11, "R4 B2 wins alone");
    pb = (ident() & ~(32'd7 << lsb_of(0))) | (32'd5 << lsb_of(0));
    wr(3'd4, pb);
    set_src(13, 1); step(2);
    rd_chk(3'd7, 14, "R4 B5 placed in slot 0");

    // R10 unplaced member ranks last
    set_src(8, 1); set_src(13, 0); set_src(10, 0); set_src(20, 1); step(2);
    rd_chk(3'd7, 21, "R10 placed C4 over unplaced B0");
    set_src(20, 0); step(2);
    rd_chk(3'd7, 9, "R10 unplaced B0 still served");
    chk(irq == 1, "R10 irq for unplaced source", irq, 1);
    set_src(8, 0);
    wr(3'd3, ident()); wr(3'd4, ident());

    // R5 spread interleave
    set_src(1, 1); set_src(8, 1); step(2);
    rd_chk(3'd7, 2, "R5 grouped A1 over B0");
    wr(3'd0, 32'h0001_0000);
    rd_chk(3'd7, 9, "R5 spread B0 over A1");
    set_src(0, 1); step(2);
    rd_chk(3'd7, 1, "R5 spread A0 over B0");
    set_src(0, 0);
    wr(3'd0, 0);

    // R8 override
    set_src(16, 1); step(2);
    rd_chk(3'd7, 2, "R8 no override");
    wr(3'd0, 32'(17) << 24);
    rd_chk(3'd7, 17, "R8 override to source 16");
    wr(3'd0, 32'(100) << 24);
    rd_chk(3'd7, 2, "R8 out-of-range override ignored");
    wr(3'd0, 32'(17) << 24);
    wr(3'd2, 32'hFFFF_7F00);
    rd_chk(3'd7, 2, "R8 masked override source ignored");
    wr(3'd2, 32'hFFFF_FF00);
    wr(3'd0, 32'h7FFF_FFFF);
    rd_chk(3'd0, 32'h7F01_0000, "R2 config writable bits");
    wr(3'd0, 0);
    set_src(1, 0); set_src(8, 0); set_src(16, 0); step(2);

    // R6 edge sense on external input 2 (source 18)
    wr(3'd6, 32'h0000_2000);
    rd_chk(3'd6, 32'h0000_2000, "R6 sense readback");
    set_src(18, 1); set_src(18, 0); step(3);
    rd_chk(3'd7, 19, "R6 pulse latched");
    rd_chk(3'd1, 32'h0000_2000, "R6 pending bit 13");
    wr(3'd1, 32'h0000_2000);
    rd_chk(3'd7, 0, "R6 cleared by write one");
    chk(irq == 0, "R6 irq after clear", irq, 0);

    // R7 level source ignores clear
    set_src(5, 1); step(2);
    wr(3'd1, 32'h0400_0000);
    rd_chk(3'd1, 32'h0400_0000, "R7 level pending survives clear");
    rd_chk(3'd7, 6, "R7 level vector");
    set_src(5, 0); step(2);
    rd_chk(3'd7, 0, "R7 level follows input low");

    // R9 vector is read-only
    wr(3'd7, 32'h0000_007F);
    rd_chk(3'd7, 0, "R9 vector write ignored");
    step(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule